// File: doc/BRIEF.md
# SPI Register Access Slave for a Loop-Current DAC Controller

This block is the serial front end of a loop-current DAC controller. An external master drives an active-low select, a serial clock that idles low and a data line. The block takes the three wires into the system clock domain through two-flop synchronizers. It captures the data bit on each falling serial-clock edge and drives its reply bit on each rising edge, most significant bit first. A frame holds a command byte and a 16-bit data word. When CRC checking is enabled, an 8-bit check byte follows them.

When the select line rises, the block judges the frame. It counts the clock edges and, in CRC mode, compares the received check byte with one it computed itself. A frame that passes commits a write to one of four holding registers (DAC code, control, offset and gain) or queues a read. A frame that fails sets a sticky error flag and changes nothing. Read data goes out during the next frame. When no read is queued and automatic readback is left on, every frame returns the fault word instead. One-cycle strobes tell downstream logic which register changed, and a separate pulse marks each accepted frame for an external watchdog.

Top module: `spi_reg_slave`

## Requirements
- R1: After reset, dac_o, ctrl_o and offset_o are 0x0000, gain_o is 0xFFFF, sdo_o is 0, and both error flags are clear.
- R2: A valid write frame updates the addressed register and pulses exactly one bit of wr_stb_o for one cycle. Command bit 7 is 0 for a write, and the low 7 bits select the register: 1 is DAC (strobe bit 0), 2 is control (bit 1), 3 is offset (bit 2) and 4 is gain (bit 3). frame_ok_o pulses once for every accepted frame.
- R3: With CRC mode off, a frame must carry exactly 24 falling clock edges. Any other count discards the frame, suppresses frame_ok_o and sets cnt_err_o.
- R4: Control bit 14 enables CRC mode. In CRC mode a frame needs exactly 32 edges, laid out as command byte, data word and check byte, so a 24-edge frame becomes a count error.
- R5: In CRC mode the check byte must equal a CRC-8 with polynomial x^8+x^2+x+1, a zero seed, MSB first, computed over the preceding 24 bits. A mismatch blocks the write and sets crc_err_o.
- R6: A valid frame with command bit 7 set queues a read. During the next frame, sdo_o shifts out the echoed command byte and then the addressed register value, MSB first, with each bit changing on a rising serial-clock edge. Address 5 returns the fault word, and unknown addresses return 0.
- R7: When no read is queued and control bit 12 is 0, a frame returns 0x05 followed by the fault word. The fault word has bit 12 for loop_fault_i, bit 11 for overtemp_i, bit 9 for the CRC error, bit 8 for the count error, bit 7 for wdt_timeout_i, and zero elsewhere. With control bit 12 set, the frame returns all zeros.
- R8: Both error flags clear when the fault word is loaded for transmission.
- R9: In CRC mode the 24 reply bits are followed on sdo_o by their own CRC-8, computed with the same rule as R5.
- R10: A write to address 5, to address 0 or to any address above 5 is accepted (frame_ok_o pulses) but changes no register and raises no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| csn_i | input | 1 | Frame select, active low |
| sclk_i | input | 1 | Serial clock, idles low |
| sdi_i | input | 1 | Serial data from master |
| sdo_o | output | 1 | Serial data to master |
| loop_fault_i | input | 1 | Loop supply fault status |
| overtemp_i | input | 1 | Over-temperature status |
| wdt_timeout_i | input | 1 | External watchdog timeout status |
| dac_o | output | 16 | DAC code register |
| ctrl_o | output | 16 | Control register |
| offset_o | output | 16 | Offset trim register |
| gain_o | output | 16 | Gain trim register |
| wr_stb_o | output | 4 | One-cycle write strobe per register |
| frame_ok_o | output | 1 | Pulse per accepted frame |
| cnt_err_o | output | 1 | Sticky clock-count error |
| crc_err_o | output | 1 | Sticky CRC error |

## Verification
A bad edge counter or a bad CRC accumulator shows up when that same frame ends, a few system cycles after select rises. The sign is a missing or spurious strobe, an unchanged register and a raised error flag. A wrong queued read or a wrong fault snapshot stays hidden until the following frame, where the reply bits differ on sdo_o. A register written outside its strobe is caught on the cycle it changes.

// File: rtl/spi_reg_pkg.sv
package spi_reg_pkg;
  localparam int CMD_W   = 8;
  localparam int DATA_W  = 16;
  localparam int CRC_W   = 8;
  localparam int BODY_W  = CMD_W + DATA_W;
  localparam int FRAME_W = BODY_W + CRC_W;
  localparam int CNT_W   = $clog2(FRAME_W) + 1;
  localparam int NUM_WR  = 4;
  localparam int CTRL_CRC_BIT    = 14;
  localparam int CTRL_NOAUTO_BIT = 12;
  localparam logic [CRC_W-1:0] CRC_POLY = 8'h07;
  localparam logic [CMD_W-1:0] AUTO_TAG = 8'h05;

  typedef enum logic [CMD_W-2:0] {
    A_DAC   = 7'd1,
    A_CTRL  = 7'd2,
    A_OFFS  = 7'd3,
    A_GAIN  = 7'd4,
    A_FAULT = 7'd5
  } addr_e;

  function automatic logic [CRC_W-1:0] crc_step(logic [CRC_W-1:0] c, logic b);
    logic fb;
    fb = c[CRC_W-1] ^ b;
    return {c[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
  endfunction

  function automatic logic [CRC_W-1:0] crc_body(logic [BODY_W-1:0] w);
    logic [CRC_W-1:0] c;
    c = '0;
    for (int i = BODY_W - 1; i >= 0; i--) c = crc_step(c, w[i]);
    return c;
  endfunction
endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
  parameter int         W       = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar k = 0; k < W; k++) begin : g_bit
    logic s1_q, s2_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s1_q <= RST_VAL[k];
        s2_q <= RST_VAL[k];
      end else begin
        s1_q <= d_i[k];
        s2_q <= s1_q;
      end
    end
    assign q_o[k] = s2_q;
  end
endmodule

// File: rtl/spi_rx.sv
module spi_rx
  import spi_reg_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               csn_i,
  input  logic               sclk_i,
  input  logic               sdi_i,
  output logic               start_o,
  output logic               end_o,
  output logic               rise_o,
  output logic [FRAME_W-1:0] shift_o,
  output logic [CNT_W-1:0]   cnt_o,
  output logic [CRC_W-1:0]   crc_o
);
  logic csn_q, sclk_q, fall;
  logic [FRAME_W-1:0] shift_q;
  logic [CNT_W-1:0]   cnt_q;
  logic [CRC_W-1:0]   crc_q;

  assign start_o = csn_q & ~csn_i;
  assign end_o   = ~csn_q & csn_i;
  assign rise_o  = ~csn_i & ~sclk_q & sclk_i;
  assign fall    = ~csn_i & sclk_q & ~sclk_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      csn_q   <= 1'b1;
      sclk_q  <= 1'b0;
      shift_q <= '0;
      cnt_q   <= '0;
      crc_q   <= '0;
    end else begin
      csn_q  <= csn_i;
      sclk_q <= sclk_i;
      if (start_o) begin
        cnt_q <= '0;
        crc_q <= '0;
      end else if (fall) begin
        shift_q <= {shift_q[FRAME_W-2:0], sdi_i};
        if (cnt_q != '1) cnt_q <= cnt_q + 1'b1;
        if (cnt_q < CNT_W'(BODY_W)) crc_q <= crc_step(crc_q, sdi_i);
      end
    end
  end

  assign shift_o = shift_q;
  assign cnt_o   = cnt_q;
  assign crc_o   = crc_q;

  p_cnt_frozen_idle_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (csn_i && csn_q) |=> $stable(cnt_q));
endmodule

// File: rtl/spi_regs.sv
module spi_regs
  import spi_reg_pkg::*;
(
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          start_i,
  input  logic                          end_i,
  input  logic [FRAME_W-1:0]            shift_i,
  input  logic [CNT_W-1:0]              cnt_i,
  input  logic [CRC_W-1:0]              crc_i,
  input  logic                          loop_fault_i,
  input  logic                          overtemp_i,
  input  logic                          wdt_timeout_i,
  output logic [NUM_WR-1:0][DATA_W-1:0] regs_o,
  output logic [NUM_WR-1:0]             stb_o,
  output logic                          ok_o,
  output logic                          cnt_err_o,
  output logic                          crc_err_o,
  output logic                          tx_load_o,
  output logic [FRAME_W-1:0]            tx_word_o
);
  logic crc_en, no_auto, cnt_ok, crc_ok, good, is_rd;
  logic [CMD_W-1:0]  cmd;
  logic [DATA_W-1:0] data, rd_data, fault_w;
  logic [BODY_W-1:0] resp;
  logic              fault_sel;
  logic              pend_q, ok_q, cnt_err_q, crc_err_q;
  logic [CMD_W-1:0]  pend_cmd_q;

  assign crc_en  = regs_o[A_CTRL-1][CTRL_CRC_BIT];
  assign no_auto = regs_o[A_CTRL-1][CTRL_NOAUTO_BIT];
  assign cmd     = crc_en ? shift_i[FRAME_W-1 -: CMD_W] : shift_i[BODY_W-1 -: CMD_W];
  assign data    = crc_en ? shift_i[FRAME_W-CMD_W-1 -: DATA_W] : shift_i[DATA_W-1:0];
  assign cnt_ok  = cnt_i == (crc_en ? CNT_W'(FRAME_W) : CNT_W'(BODY_W));
  assign crc_ok  = !crc_en || (shift_i[CRC_W-1:0] == crc_i);
  assign good    = end_i && cnt_ok && crc_ok;
  assign is_rd   = cmd[CMD_W-1];

  for (genvar k = 0; k < NUM_WR; k++) begin : g_reg
    localparam logic [DATA_W-1:0] RV = (k == A_GAIN - 1) ? '1 : '0;
    logic [DATA_W-1:0] q;
    logic              s;
    logic              hit;
    assign hit = good && !is_rd && (cmd[CMD_W-2:0] == (CMD_W-1)'(k + 1));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        q <= RV;
        s <= 1'b0;
      end else begin
        s <= hit;
        if (hit) q <= data;
      end
    end
    assign regs_o[k] = q;
    assign stb_o[k]  = s;
  end

  assign fault_w = {3'b000, loop_fault_i, overtemp_i, 1'b0, crc_err_q, cnt_err_q,
                    wdt_timeout_i, 7'b0000000};

  always_comb begin
    case (pend_cmd_q[CMD_W-2:0])
      A_DAC, A_CTRL, A_OFFS, A_GAIN: rd_data = regs_o[pend_cmd_q[CMD_W-2:0] - 1'b1];
      A_FAULT:                       rd_data = fault_w;
      default:                       rd_data = '0;
    endcase
    if (pend_q) begin
      resp      = {pend_cmd_q, rd_data};
      fault_sel = pend_cmd_q[CMD_W-2:0] == A_FAULT;
    end else if (!no_auto) begin
      resp      = {AUTO_TAG, fault_w};
      fault_sel = 1'b1;
    end else begin
      resp      = '0;
      fault_sel = 1'b0;
    end
  end

  assign tx_load_o = start_i;
  assign tx_word_o = {resp, crc_en ? crc_body(resp) : {CRC_W{1'b0}}};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q     <= 1'b0;
      pend_cmd_q <= '0;
      ok_q       <= 1'b0;
      cnt_err_q  <= 1'b0;
      crc_err_q  <= 1'b0;
    end else begin
      ok_q <= good;
      if (start_i) begin
        pend_q <= 1'b0;
        if (fault_sel) begin
          cnt_err_q <= 1'b0;
          crc_err_q <= 1'b0;
        end
      end
      if (end_i && !cnt_ok) cnt_err_q <= 1'b1;
      if (end_i && cnt_ok && !crc_ok) crc_err_q <= 1'b1;
      if (good && is_rd) begin
        pend_q     <= 1'b1;
        pend_cmd_q <= cmd;
      end
    end
  end

  assign ok_o      = ok_q;
  assign cnt_err_o = cnt_err_q;
  assign crc_err_o = crc_err_q;

  p_stb_onehot_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(stb_o));
  p_stb_with_ok_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|stb_o) |-> ok_o);
  p_dac_only_on_stb_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(regs_o[A_DAC-1]) |-> stb_o[A_DAC-1]);
  p_gain_only_on_stb_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(regs_o[A_GAIN-1]) |-> stb_o[A_GAIN-1]);
  p_crc_err_needs_en_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(crc_err_q) |-> crc_en);
  p_ok_not_cnt_err_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ok_o |-> !$rose(cnt_err_q));
endmodule

// File: rtl/spi_tx.sv
module spi_tx
  import spi_reg_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic [FRAME_W-1:0] word_i,
  input  logic               rise_i,
  output logic               sdo_o
);
  logic [FRAME_W-1:0] sh_q;
  logic               sdo_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q  <= '0;
      sdo_q <= 1'b0;
    end else if (load_i) begin
      sh_q <= word_i;
    end else if (rise_i) begin
      sdo_q <= sh_q[FRAME_W-1];
      sh_q  <= {sh_q[FRAME_W-2:0], 1'b0};
    end
  end

  assign sdo_o = sdo_q;

  p_sdo_moves_on_rise_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rise_i |=> $stable(sdo_q));
endmodule

// File: rtl/spi_reg_slave.sv
module spi_reg_slave
  import spi_reg_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              csn_i,
  input  logic              sclk_i,
  input  logic              sdi_i,
  output logic              sdo_o,
  input  logic              loop_fault_i,
  input  logic              overtemp_i,
  input  logic              wdt_timeout_i,
  output logic [DATA_W-1:0] dac_o,
  output logic [DATA_W-1:0] ctrl_o,
  output logic [DATA_W-1:0] offset_o,
  output logic [DATA_W-1:0] gain_o,
  output logic [NUM_WR-1:0] wr_stb_o,
  output logic              frame_ok_o,
  output logic              cnt_err_o,
  output logic              crc_err_o
);
  logic [2:0] sync_q;
  logic start, fin, rise, tx_load;
  logic [FRAME_W-1:0] shift, tx_word;
  logic [CNT_W-1:0]   cnt;
  logic [CRC_W-1:0]   crc;
  logic [NUM_WR-1:0][DATA_W-1:0] regs;

  spi_sync #(.W(3), .RST_VAL(3'b001)) i_sync (
    .clk_i (clk_i), .rst_ni (rst_ni),
    .d_i   ({sdi_i, sclk_i, csn_i}),
    .q_o   (sync_q)
  );

  spi_rx i_rx (
    .clk_i (clk_i), .rst_ni (rst_ni),
    .csn_i (sync_q[0]), .sclk_i (sync_q[1]), .sdi_i (sync_q[2]),
    .start_o (start), .end_o (fin), .rise_o (rise),
    .shift_o (shift), .cnt_o (cnt), .crc_o (crc)
  );

  spi_regs i_regs (
    .clk_i (clk_i), .rst_ni (rst_ni),
    .start_i (start), .end_i (fin), .shift_i (shift), .cnt_i (cnt), .crc_i (crc),
    .loop_fault_i (loop_fault_i), .overtemp_i (overtemp_i), .wdt_timeout_i (wdt_timeout_i),
    .regs_o (regs), .stb_o (wr_stb_o), .ok_o (frame_ok_o),
    .cnt_err_o (cnt_err_o), .crc_err_o (crc_err_o),
    .tx_load_o (tx_load), .tx_word_o (tx_word)
  );

  spi_tx i_tx (
    .clk_i (clk_i), .rst_ni (rst_ni),
    .load_i (tx_load), .word_i (tx_word), .rise_i (rise),
    .sdo_o (sdo_o)
  );

  assign dac_o    = regs[A_DAC-1];
  assign ctrl_o   = regs[A_CTRL-1];
  assign offset_o = regs[A_OFFS-1];
  assign gain_o   = regs[A_GAIN-1];
endmodule

// File: tb/test_spi_reg_slave.sv
module test_spi_reg_slave;
  logic clk = 1'b0, rst_n = 1'b0;
  logic csn = 1'b1, sclk = 1'b0, sdi = 1'b0;
  logic loop_f = 1'b0, otemp = 1'b0, wdt = 1'b0;
  logic sdo, ok, cerr, rerr;
  logic [15:0] dac, ctrl, offs, gain;
  logic [3:0] stb;
  int n_chk = 0, n_fail = 0;
  int stb_n [4];
  int ok_n = 0;

  always #2.5 clk = ~clk;

  spi_reg_slave i_spi_reg_slave (
    .clk_i (clk), .rst_ni (rst_n), .csn_i (csn), .sclk_i (sclk), .sdi_i (sdi),
    .sdo_o (sdo), .loop_fault_i (loop_f), .overtemp_i (otemp), .wdt_timeout_i (wdt),
    .dac_o (dac), .ctrl_o (ctrl), .offset_o (offs), .gain_o (gain),
    .wr_stb_o (stb), .frame_ok_o (ok), .cnt_err_o (cerr), .crc_err_o (rerr)
  );

  initial for (int k = 0; k < 4; k++) stb_n[k] = 0;
  always @(negedge clk) begin
    for (int k = 0; k < 4; k++) if (stb[k]) stb_n[k]++;
    if (ok) ok_n++;
  end

  function automatic logic [7:0] crc8(logic [23:0] w);
    logic [7:0] c = 8'h00;
    for (int i = 23; i >= 0; i--) begin
      logic fb = c[7] ^ w[i];
      c = {c[6:0], 1'b0};
      if (fb) c = c ^ 8'h07;
    end
    return c;
  endfunction

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic xfer(int nb, logic [31:0] w, output logic [31:0] r);
    r = '0;
    @(negedge clk) csn = 1'b0;
    repeat (8) @(negedge clk);
    for (int i = 0; i < nb; i++) begin
      sclk = 1'b1;
      sdi  = w[31-i];
      repeat (8) @(negedge clk);
      r[31-i] = sdo;
      sclk = 1'b0;
      repeat (8) @(negedge clk);
    end
    csn = 1'b1;
    repeat (10) @(negedge clk);
  endtask

  function automatic logic [31:0] f24(logic [7:0] c, logic [15:0] d);
    return {c, d, 8'h00};
  endfunction
  function automatic logic [31:0] f32(logic [7:0] c, logic [15:0] d);
    return {c, d, crc8({c, d})};
  endfunction

  task automatic t_reset;
    check("R1", "dac", dac, 0);
    check("R1", "ctrl", ctrl, 0);
    check("R1", "offset", offs, 0);
    check("R1", "gain", gain, 32'hFFFF);
    check("R1", "sdo/flags", {sdo, cerr, rerr}, 0);
  endtask

  task automatic t_write;
    logic [31:0] r;
    int s0 = stb_n[0], s2 = stb_n[2], s3 = stb_n[3], o = ok_n;
    xfer(24, f24(8'h01, 16'h1234), r);
    check("R2", "dac value", dac, 32'h1234);
    check("R2", "dac strobe", stb_n[0] - s0, 1);
    xfer(24, f24(8'h04, 16'h8001), r);
    xfer(24, f24(8'h03, 16'hFFFE), r);
    check("R2", "gain value", gain, 32'h8001);
    check("R2", "offset value", offs, 32'hFFFE);
    check("R2", "strobes g/o", {stb_n[3] - s3, stb_n[2] - s2}, {32'd1, 32'd1});
    check("R2", "frame_ok pulses", ok_n - o, 3);
  endtask

  task automatic t_ignore;
    logic [31:0] r;
    int s = stb_n[0] + stb_n[1] + stb_n[2] + stb_n[3], o = ok_n;
    xfer(24, f24(8'h05, 16'hAAAA), r);
    xfer(24, f24(8'h07, 16'h5555), r);
    xfer(24, f24(8'h00, 16'h0F00), r);
    check("R10", "regs unchanged", {dac, gain}, {16'h1234, 16'h8001});
    check("R10", "ctrl/offset unchanged", {ctrl, offs}, {16'h0000, 16'hFFFE});
    check("R10", "no strobes", stb_n[0] + stb_n[1] + stb_n[2] + stb_n[3] - s, 0);
    check("R10", "accepted", ok_n - o, 3);
  endtask

  task automatic t_count;
    logic [31:0] r;
    int o = ok_n;
    xfer(23, f24(8'h01, 16'h5555), r);
    check("R3", "cnt_err after 23", cerr, 1);
    xfer(25, f24(8'h01, 16'h5555), r);
    check("R3", "dac after 23/25", dac, 32'h1234);
    check("R3", "no frame_ok", ok_n - o, 0);
    check("R3", "crc_err quiet", rerr, 0);
  endtask

  task automatic t_autoread;
    logic [31:0] r;
    loop_f = 1'b1;
    xfer(24, f24(8'h00, 16'h0000), r);
    check("R7", "auto fault word", r, {8'h05, 16'h1100, 8'h00});
    check("R8", "cnt_err cleared", cerr, 0);
    loop_f = 1'b0;
    otemp  = 1'b1;
    wdt    = 1'b1;
    xfer(24, f24(8'h00, 16'h0000), r);
    check("R8", "fault word after clear", r, {8'h05, 16'h0880, 8'h00});
    otemp = 1'b0;
    wdt   = 1'b0;
  endtask

  task automatic t_read;
    logic [31:0] r;
    xfer(24, f24(8'h81, 16'h0000), r);
    xfer(24, f24(8'h84, 16'h0000), r);
    check("R6", "read dac", r, {8'h81, 16'h1234, 8'h00});
    xfer(24, f24(8'h09, 16'h0000), r);
    check("R6", "read gain", r, {8'h84, 16'h8001, 8'h00});
  endtask

  task automatic t_noauto;
    logic [31:0] r;
    xfer(24, f24(8'h02, 16'h1000), r);
    xfer(24, f24(8'h00, 16'h0000), r);
    check("R7", "auto readback off", r, 0);
  endtask

  task automatic t_crc;
    logic [31:0] r;
    int s0;
    xfer(24, f24(8'h02, 16'h5000), r);
    check("R4", "ctrl crc on", ctrl, 32'h5000);
    xfer(24, f24(8'h01, 16'h0BAD), r);
    check("R4", "24-bit in crc mode", {cerr, dac}, {16'h1, 16'h1234});
    s0 = stb_n[0];
    xfer(32, f32(8'h01, 16'h0F0F) ^ 32'h0000_00FF, r);
    check("R5", "bad crc blocked", {rerr, dac}, {16'h1, 16'h1234});
    check("R5", "no strobe on bad crc", stb_n[0] - s0, 0);
    xfer(32, f32(8'h01, 16'h0F0F), r);
    check("R5", "good crc commits", dac, 32'h0F0F);
    xfer(32, f32(8'h81, 16'h0000), r);
    xfer(32, f32(8'h00, 16'h0000), r);
    check("R9", "read with crc", r, f32(8'h81, 16'h0F0F));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog all-requirements actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_write();
    t_ignore();
    t_count();
    t_autoread();
    t_read();
    t_noauto();
    t_crc();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule